// File: doc/BRIEF.md
# Two-Then-One Bit Successive-Approximation Sequencer

This block holds the digital sequencing and code correction of an 8-bit successive-approximation converter. The converter has three comparators: a low outer, a center and a high outer. Each comparator sits behind its own threshold code. After a start pulse the block runs four coarse steps. Each coarse step resolves two bits from the thermometer pattern of all three comparators. A fifth, fine step then resolves one bit from the center comparator alone. The coarse steps overlap by one redundant binary bit. The final code is the saturated signed sum of all decisions, so a small coarse error is absorbed rather than carried into the result.

Steps are self-timed. A step completes when the comparator ready strobe arrives, not after a fixed number of clocks. During the fine step all three thresholds are equal. On one conversion in every 2^CAL_LOG2, the two outer decisions taken in that step are compared with the center decision. Each outer comparator's 6-bit trim counter then moves one count toward agreement.

The sequencer has five states: `ST_IDLE`, `ST_SAMPLE`, `ST_COARSE`, `ST_FINE` and `ST_DONE`. Its transitions are:
- start-accept: `ST_IDLE` to `ST_SAMPLE` when `start_i` is high.
- track-end: `ST_SAMPLE` to `ST_COARSE`, unconditional.
- coarse-advance: `ST_COARSE` stays in `ST_COARSE` on a strobe before the last coarse step.
- coarse-exit: `ST_COARSE` to `ST_FINE` on the strobe of the last coarse step.
- fine-resolve: `ST_FINE` to `ST_DONE` on the strobe.
- retire: `ST_DONE` to `ST_IDLE`, unconditional.

Top module: `sar2t1_ctrl`

## Requirements
- R1: After synchronous reset the block is idle: `busy_o`, `sample_o`, `done_o` and `cal_o` are 0, both trim outputs read 32 (mid-scale), and all three threshold outputs read 128.
- R2: A `start_i` pulse while idle makes `sample_o` and `busy_o` high in the following cycle. A `start_i` pulse while `busy_o` is high is ignored: `sample_o` stays 0 and the thresholds keep their value.
- R3: In coarse step k (k = 0..3), the half-interval H is 32, 8, 2, 1 and the center threshold V starts at 128. The outer thresholds are V-2H (low) and V+2H (high). On a ready strobe the pattern {high, center, low} gives a digit t equal to the number of ones. V then moves by (2t-3)*H. Nothing advances without a strobe.
- R4: Any coarse pattern other than 000, 001, 011 or 111 (bit order {high, center, low}) is a bubble. A bubble still uses t equal to its count of ones. `bubble_o` is 1 from the end of a conversion until the next start if any coarse step of that conversion saw a bubble.
- R5: In the fine step all three thresholds equal V. Only the center decision b counts toward the result, which is V + b - 1. The outer decisions in this step never change the code.
- R6: With ideal comparators and an input strictly inside the 0..256 LSB range, the code is the floor of the input. A raw result below 0 reads 0, and one above 255 reads 255.
- R7: `done_o` is high for exactly one cycle with `code_o` valid. In the next cycle the block is idle.
- R8: Conversions are counted from reset. Conversion n calibrates when n mod 2^CAL_LOG2 is 0, and `cal_o` is high during its fine step only.
- R9: On the fine-step strobe of a calibrating conversion, an outer comparator that disagrees with the center moves its trim one count. It decrements if the outer comparator read 1 and increments if it read 0. The count saturates at 0 and 63. At all other times the trims hold.
- R10: The threshold outputs always satisfy low <= center <= high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Conversion start pulse |
| cmp_rdy_i | input | 1 | Comparator completion strobe |
| cmp_lo_i | input | 1 | Low outer comparator decision |
| cmp_mid_i | input | 1 | Center comparator decision |
| cmp_hi_i | input | 1 | High outer comparator decision |
| sample_o | output | 1 | Track phase of the sampling switches |
| busy_o | output | 1 | Conversion in progress |
| cal_o | output | 1 | Fine step of a calibrating conversion |
| dac_lo_o | output | 10 | Low outer threshold code, signed |
| dac_mid_o | output | 10 | Center threshold code, signed |
| dac_hi_o | output | 10 | High outer threshold code, signed |
| done_o | output | 1 | Result-valid pulse |
| code_o | output | 8 | Corrected conversion result |
| bubble_o | output | 1 | Bubble seen in the last conversion |
| trim_lo_o | output | 6 | Low outer comparator trim |
| trim_hi_o | output | 6 | High outer comparator trim |

## Verification
The fine-step strobe of a calibrating conversion does two things on the same clock edge. It latches the corrected code and it may step both trim counters. The bench shortens the calibration period to every fourth conversion. It then drives outer fine decisions that disagree with the center, sometimes forced and sometimes random, in the same cycle as the center decision. At the `done_o` pulse it judges the code against its own weighted sum and both trims against its own saturating model. Long runs of forced disagreement push the trims into both saturation limits while the codes are still checked.

// File: rtl/sar2t1_pkg.sv
package sar2t1_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_COARSE,
        ST_FINE,
        ST_DONE
    } seq_state_t;

    // Half-interval of coarse step k; the last coarse step is the redundant one.
    function automatic int half_step(input int k, input int nsteps, input int code_w);
        if (k >= nsteps - 1) begin
            return 1;
        end
        return 1 << (code_w - 3 - 2 * k);
    endfunction

endpackage

// File: rtl/sar2t1_therm.sv
module sar2t1_therm (
    input  logic       lo_i,
    input  logic       mid_i,
    input  logic       hi_i,
    output logic [1:0] digit_o,
    output logic       bubble_o
);

    always_comb begin
        digit_o  = {1'b0, lo_i} + {1'b0, mid_i} + {1'b0, hi_i};
        bubble_o = (hi_i & ~mid_i) | (mid_i & ~lo_i);
    end

endmodule

// File: rtl/sar2t1_trim.sv
module sar2t1_trim #(
    parameter int TRIM_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_i,
    input  logic              outer_i,
    input  logic              center_i,
    output logic [TRIM_W-1:0] trim_o
);

    localparam logic [TRIM_W-1:0] T_MID = TRIM_W'(1) << (TRIM_W - 1);
    localparam logic [TRIM_W-1:0] T_MAX = '1;

    logic [TRIM_W-1:0] trim_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            trim_q <= T_MID;
        end else if (upd_i && (outer_i != center_i)) begin
            if (outer_i) begin
                if (trim_q != '0) trim_q <= trim_q - TRIM_W'(1);
            end else begin
                if (trim_q != T_MAX) trim_q <= trim_q + TRIM_W'(1);
            end
        end
    end

    assign trim_o = trim_q;

endmodule

// File: rtl/sar2t1_seq.sv
module sar2t1_seq
    import sar2t1_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int CAL_LOG2 = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  logic                     rdy_i,
    input  logic [1:0]               digit_i,
    input  logic                     bubble_i,
    input  logic                     mid_i,
    output logic                     sample_o,
    output logic                     busy_o,
    output logic                     cal_o,
    output logic                     cal_upd_o,
    output logic                     done_o,
    output logic signed [CODE_W+1:0] ctr_o,
    output logic signed [CODE_W+1:0] half_o,
    output logic [CODE_W-1:0]        code_o,
    output logic                     bubble_o
);

    localparam int STEPS  = CODE_W / 2;
    localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam int DAC_W  = CODE_W + 2;
    localparam logic signed [DAC_W-1:0] V_START  = DAC_W'(1 << (CODE_W - 1));
    localparam logic signed [DAC_W-1:0] CODE_TOP = DAC_W'((1 << CODE_W) - 1);

    seq_state_t st_q, st_d;

    logic [STEP_W-1:0]        step_q;
    logic signed [DAC_W-1:0]  v_q;
    logic signed [DAC_W-1:0]  half_w;
    logic signed [DAC_W-1:0]  odd_w;
    logic signed [DAC_W-1:0]  v_next;
    logic signed [DAC_W-1:0]  fine_val;
    logic [CODE_W-1:0]        code_sat;
    logic [CODE_W-1:0]        code_q;
    logic [CAL_LOG2-1:0]      conv_q;
    logic                     cal_q;
    logic                     bub_q;
    logic                     step_last;

    assign step_last = (step_q == STEP_W'(STEPS - 1));

    always_comb begin
        half_w = DAC_W'(half_step(int'(step_q), STEPS, CODE_W));
        // (2t-3) as a signed odd value: {~t[1], t[0], 1}
        odd_w  = DAC_W'($signed({~digit_i[1], digit_i[0], 1'b1}));
        v_next = v_q + odd_w * half_w;
        fine_val = mid_i ? v_q : (v_q - DAC_W'(1));
        if (fine_val[DAC_W-1]) begin
            code_sat = '0;
        end else if (fine_val > CODE_TOP) begin
            code_sat = '1;
        end else begin
            code_sat = fine_val[CODE_W-1:0];
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next-state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start_i) st_d = ST_SAMPLE;
            ST_SAMPLE: st_d = ST_COARSE;
            ST_COARSE: if (rdy_i && step_last) st_d = ST_FINE;
            ST_FINE:   if (rdy_i) st_d = ST_DONE;
            ST_DONE:   st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        sample_o  = (st_q == ST_SAMPLE);
        busy_o    = (st_q != ST_IDLE);
        cal_o     = (st_q == ST_FINE) && cal_q;
        cal_upd_o = (st_q == ST_FINE) && cal_q && rdy_i;
        done_o    = (st_q == ST_DONE);
        ctr_o     = v_q;
        half_o    = (st_q == ST_COARSE) ? half_w : '0;
        code_o    = code_q;
        bubble_o  = bub_q;
    end

    // datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
            v_q    <= V_START;
            conv_q <= '0;
            cal_q  <= 1'b0;
            bub_q  <= 1'b0;
            code_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        step_q <= '0;
                        v_q    <= V_START;
                        bub_q  <= 1'b0;
                        cal_q  <= (conv_q == '0);
                    end
                end
                ST_COARSE: begin
                    if (rdy_i) begin
                        v_q   <= v_next;
                        bub_q <= bub_q | bubble_i;
                        if (!step_last) step_q <= step_q + STEP_W'(1);
                    end
                end
                ST_FINE: begin
                    if (rdy_i) code_q <= code_sat;
                end
                ST_DONE: begin
                    conv_q <= conv_q + CAL_LOG2'(1);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sar2t1_ctrl.sv
module sar2t1_ctrl #(
    parameter int CODE_W   = 8,
    parameter int TRIM_W   = 6,
    parameter int CAL_LOG2 = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  logic                     cmp_rdy_i,
    input  logic                     cmp_lo_i,
    input  logic                     cmp_mid_i,
    input  logic                     cmp_hi_i,
    output logic                     sample_o,
    output logic                     busy_o,
    output logic                     cal_o,
    output logic signed [CODE_W+1:0] dac_lo_o,
    output logic signed [CODE_W+1:0] dac_mid_o,
    output logic signed [CODE_W+1:0] dac_hi_o,
    output logic                     done_o,
    output logic [CODE_W-1:0]        code_o,
    output logic                     bubble_o,
    output logic [TRIM_W-1:0]        trim_lo_o,
    output logic [TRIM_W-1:0]        trim_hi_o
);

    localparam int DAC_W = CODE_W + 2;
    localparam int N_OUT = 2;

    logic [1:0]              digit_w;
    logic                    bub_w;
    logic                    cal_upd_w;
    logic signed [DAC_W-1:0] ctr_w;
    logic signed [DAC_W-1:0] half_w;
    logic [N_OUT-1:0]        outer_w;
    logic [TRIM_W-1:0]       trim_w [N_OUT];

    sar2t1_therm u_therm (
        .lo_i     (cmp_lo_i),
        .mid_i    (cmp_mid_i),
        .hi_i     (cmp_hi_i),
        .digit_o  (digit_w),
        .bubble_o (bub_w)
    );

    sar2t1_seq #(
        .CODE_W   (CODE_W),
        .CAL_LOG2 (CAL_LOG2)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .rdy_i     (cmp_rdy_i),
        .digit_i   (digit_w),
        .bubble_i  (bub_w),
        .mid_i     (cmp_mid_i),
        .sample_o  (sample_o),
        .busy_o    (busy_o),
        .cal_o     (cal_o),
        .cal_upd_o (cal_upd_w),
        .done_o    (done_o),
        .ctr_o     (ctr_w),
        .half_o    (half_w),
        .code_o    (code_o),
        .bubble_o  (bubble_o)
    );

    assign outer_w = {cmp_hi_i, cmp_lo_i};

    for (genvar g = 0; g < N_OUT; g++) begin : g_trim
        sar2t1_trim #(
            .TRIM_W (TRIM_W)
        ) u_trim (
            .clk      (clk),
            .rst      (rst),
            .upd_i    (cal_upd_w),
            .outer_i  (outer_w[g]),
            .center_i (cmp_mid_i),
            .trim_o   (trim_w[g])
        );
    end

    assign trim_lo_o = trim_w[0];
    assign trim_hi_o = trim_w[1];

    assign dac_mid_o = ctr_w;
    assign dac_lo_o  = ctr_w - (half_w <<< 1);
    assign dac_hi_o  = ctr_w + (half_w <<< 1);

endmodule

// File: rtl/sar2t1_ctrl_chk.sv
module sar2t1_ctrl_chk #(
    parameter int CODE_W = 8,
    parameter int TRIM_W = 6
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     start_i,
    input logic                     cmp_rdy_i,
    input logic                     cmp_lo_i,
    input logic                     cmp_mid_i,
    input logic                     cmp_hi_i,
    input logic                     sample_o,
    input logic                     busy_o,
    input logic                     cal_o,
    input logic signed [CODE_W+1:0] dac_lo_o,
    input logic signed [CODE_W+1:0] dac_mid_o,
    input logic signed [CODE_W+1:0] dac_hi_o,
    input logic                     done_o,
    input logic [TRIM_W-1:0]        trim_lo_o,
    input logic [TRIM_W-1:0]        trim_hi_o
);

    p_start_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (sample_o && busy_o));

    p_start_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (start_i && busy_o) |=> !sample_o);

    p_fine_flat_r5: assert property (@(posedge clk) disable iff (rst)
        cal_o |-> (dac_lo_o == dac_mid_o && dac_hi_o == dac_mid_o));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !busy_o));

    p_cal_in_conv_r8: assert property (@(posedge clk) disable iff (rst)
        cal_o |-> (busy_o && !sample_o && !done_o));

    p_trim_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !cal_o |=> ($stable(trim_lo_o) && $stable(trim_hi_o)));

    p_trim_lo_agree_r9: assert property (@(posedge clk) disable iff (rst)
        (cmp_rdy_i && cmp_lo_i == cmp_mid_i) |=> $stable(trim_lo_o));

    p_trim_hi_agree_r9: assert property (@(posedge clk) disable iff (rst)
        (cmp_rdy_i && cmp_hi_i == cmp_mid_i) |=> $stable(trim_hi_o));

    p_dac_order_r10: assert property (@(posedge clk) disable iff (rst)
        (dac_lo_o <= dac_mid_o && dac_mid_o <= dac_hi_o));

endmodule

bind sar2t1_ctrl sar2t1_ctrl_chk #(
    .CODE_W (CODE_W),
    .TRIM_W (TRIM_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .cmp_rdy_i (cmp_rdy_i),
    .cmp_lo_i  (cmp_lo_i),
    .cmp_mid_i (cmp_mid_i),
    .cmp_hi_i  (cmp_hi_i),
    .sample_o  (sample_o),
    .busy_o    (busy_o),
    .cal_o     (cal_o),
    .dac_lo_o  (dac_lo_o),
    .dac_mid_o (dac_mid_o),
    .dac_hi_o  (dac_hi_o),
    .done_o    (done_o),
    .trim_lo_o (trim_lo_o),
    .trim_hi_o (trim_hi_o)
);

// File: tb/sar2t1_ctrl_tb.sv
`timescale 1ns/1ps
module sar2t1_ctrl_tb;

    localparam int CAL_LOG2 = 2;
    localparam int CAL_PER  = 1 << CAL_LOG2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic cmp_rdy_i = 1'b0;
    logic cmp_lo_i = 1'b0;
    logic cmp_mid_i = 1'b0;
    logic cmp_hi_i = 1'b0;
    logic sample_o, busy_o, cal_o, done_o, bubble_o;
    logic signed [9:0] dac_lo_o, dac_mid_o, dac_hi_o;
    logic [7:0] code_o;
    logic [5:0] trim_lo_o, trim_hi_o;

    int total = 0;
    int bad = 0;
    int conv_idx = 0;
    int exp_tlo = 32;
    int exp_thi = 32;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sar2t1_ctrl #(
        .CODE_W   (8),
        .TRIM_W   (6),
        .CAL_LOG2 (CAL_LOG2)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .cmp_rdy_i (cmp_rdy_i),
        .cmp_lo_i  (cmp_lo_i),
        .cmp_mid_i (cmp_mid_i),
        .cmp_hi_i  (cmp_hi_i),
        .sample_o  (sample_o),
        .busy_o    (busy_o),
        .cal_o     (cal_o),
        .dac_lo_o  (dac_lo_o),
        .dac_mid_o (dac_mid_o),
        .dac_hi_o  (dac_hi_o),
        .done_o    (done_o),
        .code_o    (code_o),
        .bubble_o  (bubble_o),
        .trim_lo_o (trim_lo_o),
        .trim_hi_o (trim_hi_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic bit above(input int vin2, input int thr);
        return vin2 > 2 * thr;
    endfunction

    function automatic bit is_bubble(input logic [2:0] p);
        return !(p == 3'b000 || p == 3'b001 || p == 3'b011 || p == 3'b111);
    endfunction

    function automatic int trim_step(input int cur, input logic outer, input logic center);
        if (outer == center) return cur;
        if (outer) return (cur > 0) ? cur - 1 : 0;
        return (cur < 63) ? cur + 1 : 63;
    endfunction

    // vin2: input in half-LSB units (2x+1 is the middle of code x)
    task automatic convert(input int vin2, input int bub_step, input logic [2:0] bub_pat,
                           input bit force_outer, input logic f_lo, input logic f_hi,
                           input bit busy_start, input int exp_x);
        int v;
        int h;
        int t;
        int cw;
        bit any_bub;
        bit cal;
        logic [2:0] pat;
        logic b;
        v = 128;
        any_bub = 1'b0;
        cal = (conv_idx % CAL_PER) == 0;
        while (busy_o) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(sample_o === 1'b1 && busy_o === 1'b1, "R2 start-accept", int'(sample_o), 1);
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            h = (k == 3) ? 1 : (32 >> (2 * k));
            repeat ($urandom_range(2, 0)) begin
                cmp_rdy_i = 1'b0;
                @(negedge clk);
            end
            if (busy_start && k == 1) begin
                cmp_rdy_i = 1'b0;
                start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
                chk(sample_o === 1'b0, "R2 start-ignored", int'(sample_o), 0);
                chk(int'(dac_mid_o) == v, "R2 start-ignored dac", int'(dac_mid_o), v);
            end
            chk(int'(dac_mid_o) == v, "R3 center threshold", int'(dac_mid_o), v);
            chk(int'(dac_lo_o) == v - 2 * h && int'(dac_hi_o) == v + 2 * h,
                "R3 outer thresholds", int'(dac_hi_o) - int'(dac_lo_o), 4 * h);
            chk(dac_lo_o <= dac_mid_o && dac_mid_o <= dac_hi_o, "R10 order",
                int'(dac_lo_o), int'(dac_hi_o));
            pat = {above(vin2, v + 2 * h), above(vin2, v), above(vin2, v - 2 * h)};
            if (k == bub_step) pat = bub_pat;
            if (is_bubble(pat)) any_bub = 1'b1;
            t = int'(pat[0]) + int'(pat[1]) + int'(pat[2]);
            cmp_hi_i  = pat[2];
            cmp_mid_i = pat[1];
            cmp_lo_i  = pat[0];
            cmp_rdy_i = 1'b1;
            v = v + (2 * t - 3) * h;
            @(negedge clk);
            cmp_rdy_i = 1'b0;
        end
        repeat ($urandom_range(2, 0)) @(negedge clk);
        chk(int'(dac_lo_o) == v && int'(dac_mid_o) == v && int'(dac_hi_o) == v,
            "R5 fine thresholds flat", int'(dac_mid_o), v);
        chk(cal_o === cal, "R8 cal flag", int'(cal_o), int'(cal));
        chk(done_o === 1'b0, "R3 no advance without strobe", int'(done_o), 0);
        b = above(vin2, v);
        cmp_mid_i = b;
        cmp_lo_i  = force_outer ? f_lo : b;
        cmp_hi_i  = force_outer ? f_hi : b;
        if (cal) begin
            exp_tlo = trim_step(exp_tlo, cmp_lo_i, b);
            exp_thi = trim_step(exp_thi, cmp_hi_i, b);
        end
        cmp_rdy_i = 1'b1;
        @(negedge clk);
        cmp_rdy_i = 1'b0;
        cw = v + int'(b) - 1;
        if (cw < 0) cw = 0;
        if (cw > 255) cw = 255;
        chk(done_o === 1'b1, "R7 done pulse", int'(done_o), 1);
        chk(int'(code_o) == cw, "R5 corrected code", int'(code_o), cw);
        if (exp_x >= 0) chk(int'(code_o) == exp_x, "R6 code equals input", int'(code_o), exp_x);
        chk(bubble_o === any_bub, "R4 bubble flag", int'(bubble_o), int'(any_bub));
        chk(int'(trim_lo_o) == exp_tlo, "R9 low trim", int'(trim_lo_o), exp_tlo);
        chk(int'(trim_hi_o) == exp_thi, "R9 high trim", int'(trim_hi_o), exp_thi);
        @(negedge clk);
        chk(done_o === 1'b0 && busy_o === 1'b0, "R7 back to idle", int'(busy_o), 0);
        conv_idx++;
    endtask

    initial begin
        logic [2:0] bpats [4];
        int x;
        int m;
        bpats[0] = 3'b010;
        bpats[1] = 3'b100;
        bpats[2] = 3'b101;
        bpats[3] = 3'b110;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy_o === 1'b0 && sample_o === 1'b0 && done_o === 1'b0 && cal_o === 1'b0,
            "R1 idle after reset", int'(busy_o), 0);
        chk(int'(trim_lo_o) == 32 && int'(trim_hi_o) == 32, "R1 trim mid-scale",
            int'(trim_lo_o), 32);
        chk(int'(dac_mid_o) == 128 && int'(dac_lo_o) == 128 && int'(dac_hi_o) == 128,
            "R1 thresholds", int'(dac_mid_o), 128);

        // directed corners
        convert(1, -1, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 0);        // R6 bottom code
        convert(511, -1, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 255);    // R6 top code
        convert(2000, -1, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 255);   // R6 saturate high
        convert(-100, -1, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 0);     // R6 saturate low
        convert(257, -1, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 128);    // R2 start while busy
        for (int i = 0; i < 4; i++) begin
            convert(301, i, bpats[i], 1'b0, 1'b0, 1'b0, 1'b0, -1); // R4 each bubble
        end
        convert(77, -1, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 38);      // R5 outer ignored

        // constrained random
        for (int i = 0; i < 160; i++) begin
            x = $urandom_range(255, 0);
            m = $urandom_range(9, 0);
            if (m < 6) begin
                convert(2 * x + 1, -1, 3'b000, 1'b0, 1'b0, 1'b0,
                        ($urandom_range(7, 0) == 0), x);
            end else if (m < 8) begin
                convert(2 * x + 1, $urandom_range(3, 0), bpats[$urandom_range(3, 0)],
                        1'b0, 1'b0, 1'b0, 1'b0, -1);
            end else begin
                convert(2 * x + 1, -1, 3'b000, 1'b1, 1'($urandom_range(1, 0)),
                        1'($urandom_range(1, 0)), 1'b0, x);
            end
        end

        // R9 drive trims to the lower limit, then to the upper limit
        for (int i = 0; i < 150; i++) begin
            convert(1, -1, 3'b000, 1'b1, 1'b1, 1'b1, 1'b0, 0);
        end
        chk(int'(trim_lo_o) == 0 && int'(trim_hi_o) == 0, "R9 lower saturation",
            int'(trim_lo_o), 0);
        for (int i = 0; i < 270; i++) begin
            convert(511, -1, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 255);
        end
        chk(int'(trim_lo_o) == 63 && int'(trim_hi_o) == 63, "R9 upper saturation",
            int'(trim_hi_o), 63);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R7 act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule